// File: doc/BRIEF.md
# Xorshift32 Generator with Add-Rotate Output Hash

This block produces 32-bit pseudo-random words. Its 32-bit state is a xorshift register that advances once for each accepted request. The word it returns is not the raw state. The pre-advance state is scrambled by two dependent add-rotate stages, and the result is XORed with the post-advance state. Because the two additions are chained, they sit in separate pipeline stages. A result therefore appears two clock edges after its request, and a new request can be accepted on every cycle.

A client can reseed the generator through a load port. A zero seed would lock a xorshift register at zero, so it is replaced by 1. Both pipeline stages track occupancy with a two-state slot type, `SLOT_EMPTY` and `SLOT_FULL`. The transitions are simple. An accepted request moves the front slot to `SLOT_FULL`; otherwise the front slot goes to `SLOT_EMPTY`. The back slot follows the front slot one edge later and drives the valid flag.

Top module: `xs32_hash_rng`

## Requirements
- R1: After reset, `rnd_valid` is 0, `rnd_out` is 0 and the state is 1. The first request after reset therefore returns hash(1) XOR xorshift(1).
- R2: An accepted request advances the state x through three steps in this order: x ^= x<<13, then x ^= x>>17, then x ^= x<<5.
- R3: The first hash stage takes t, the state held before the advance, and computes t1 = t + rotl(t,18) modulo 2^32.
- R4: The second hash stage computes t2 = t1 + (rotl(t1,7) XOR rotl(t1,11)) modulo 2^32.
- R5: The returned word is t2 XOR the advanced state.
- R6: A request is accepted when `req`=1 and `seed_load`=0 at a rising edge. Its result is presented with `rnd_valid`=1 after the second rising edge that follows. Each accepted request yields exactly one valid word, and requests on consecutive cycles yield valid words on consecutive cycles.
- R7: When `seed_load`=1 at a rising edge, the state becomes `seed_value`. A `req` in the same cycle is not accepted and produces no valid word.
- R8: A loaded seed of 0 sets the state to 1.
- R9: While `rnd_valid`=0, `rnd_out` keeps its previous value.
- R10: A cycle with neither `req` nor `seed_load` leaves the state unchanged. This is seen in the next returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Load `seed_value` into the state |
| seed_value | input | 32 | New seed |
| req | input | 1 | Request one word |
| rnd_out | output | 32 | Hashed random word |
| rnd_valid | output | 1 | `rnd_out` holds a new word this cycle |

## Verification
The bench goes after the timing of requests. It sends long back-to-back bursts, isolated requests and idle gaps. A design that dropped or doubled a request, or that used the wrong pipeline delay, would put every later word out of step with the model. It also goes after the seed port. It applies a zero seed, a non-zero seed, and a seed load issued together with a request. A design that let the request win, or that stored zero, would emit an extra word or fall into an all-zero sequence. Across more than 10,000 words the bench checks the shift order, the rotate amounts and the order of the two additions. A swapped shift or rotate amount, or an addition fed the unhashed value, would change almost every word.

// File: rtl/xs32_pkg.sv
package xs32_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/xs32_state.sv
module xs32_state
    import xs32_pkg::*;
#(
    parameter int SH_A = 13,
    parameter int SH_B = 17,
    parameter int SH_C = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t seed,
    input  logic  step,
    output word_t cur,
    output word_t nxt
);
    localparam word_t ONE = word_t'(1);

    word_t stage_a;
    word_t stage_b;

    always_comb begin
        stage_a = cur ^ (cur << SH_A);
        stage_b = stage_a ^ (stage_a >> SH_B);
        nxt     = stage_b ^ (stage_b << SH_C);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= ONE;
        end else if (load) begin
            cur <= (seed == '0) ? ONE : seed;
        end else if (step) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/xs32_mix_front.sv
module xs32_mix_front
    import xs32_pkg::*;
#(
    parameter int ROT_A = 18
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take,
    input  word_t t_in,
    input  word_t s_in,
    output slot_e slot_q,
    output word_t t1_q,
    output word_t s_q
);
    word_t t1_d;
    slot_e slot_d;

    always_comb begin
        t1_d   = t_in + rotl(t_in, ROT_A);
        slot_d = take ? SLOT_FULL : SLOT_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_q <= '0;
            s_q  <= '0;
        end else if (take) begin
            t1_q <= t1_d;
            s_q  <= s_in;
        end
    end
endmodule

// File: rtl/xs32_mix_back.sv
module xs32_mix_back
    import xs32_pkg::*;
#(
    parameter int ROT_B = 7,
    parameter int ROT_C = 11
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e slot_in,
    input  word_t t1,
    input  word_t s,
    output logic  valid,
    output word_t out_q
);
    word_t t2;
    slot_e slot_q;

    always_comb begin
        t2 = t1 + (rotl(t1, ROT_B) ^ rotl(t1, ROT_C));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            unique case (slot_in)
                SLOT_FULL:  slot_q <= SLOT_FULL;
                SLOT_EMPTY: slot_q <= SLOT_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (slot_in == SLOT_FULL) begin
            out_q <= t2 ^ s;
        end
    end

    assign valid = (slot_q == SLOT_FULL);
endmodule

// File: rtl/xs32_hash_rng.sv
module xs32_hash_rng
    import xs32_pkg::*;
#(
    parameter int SH_A  = 13,
    parameter int SH_B  = 17,
    parameter int SH_C  = 5,
    parameter int ROT_A = 18,
    parameter int ROT_B = 7,
    parameter int ROT_C = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_load,
    input  logic [31:0] seed_value,
    input  logic        req,
    output logic [31:0] rnd_out,
    output logic        rnd_valid
);
    logic  take;
    word_t state_cur;
    word_t state_nxt;
    slot_e front_slot;
    word_t front_t1;
    word_t front_s;

    assign take = req && !seed_load;

    xs32_state #(.SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_state (
        .clk  (clk),
        .rst_n(rst_n),
        .load (seed_load),
        .seed (seed_value),
        .step (take),
        .cur  (state_cur),
        .nxt  (state_nxt)
    );

    xs32_mix_front #(.ROT_A(ROT_A)) u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .t_in  (state_cur),
        .s_in  (state_nxt),
        .slot_q(front_slot),
        .t1_q  (front_t1),
        .s_q   (front_s)
    );

    xs32_mix_back #(.ROT_B(ROT_B), .ROT_C(ROT_C)) u_back (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_in(front_slot),
        .t1     (front_t1),
        .s      (front_s),
        .valid  (rnd_valid),
        .out_q  (rnd_out)
    );
endmodule

// File: rtl/xs32_hash_rng_chk.sv
module xs32_hash_rng_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        seed_load,
    input logic [31:0] seed_value,
    input logic        req,
    input logic [31:0] rnd_out,
    input logic        rnd_valid,
    input logic [31:0] st_q
);
    // R6: an accepted request gives a valid word two edges later
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !seed_load) |=> ##1 rnd_valid);

    // R6, R7: no valid word without an accepted request two edges earlier
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> $past(req && !seed_load, 2));

    // R9: the output word holds while not valid
    assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_valid |-> $stable(rnd_out));

    // R8: a zero seed leaves the state at 1
    assert_zero_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value == 32'd0) |=> st_q == 32'd1);

    // R7: a non-zero seed is taken as is
    assert_seed_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value != 32'd0) |=> st_q == $past(seed_value));

    // R10: an idle cycle does not move the state
    assert_idle_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !seed_load) |=> $stable(st_q));

    // R2: xorshift never reaches the all-zero state
    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 32'd0);
endmodule

bind xs32_hash_rng xs32_hash_rng_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .seed_value(seed_value),
    .req       (req),
    .rnd_out   (rnd_out),
    .rnd_valid (rnd_valid),
    .st_q      (state_cur)
);

// File: tb/test_xs32_hash_rng.sv
module test_xs32_hash_rng;
    logic        clk;
    logic        rst_n;
    logic        seed_load;
    logic [31:0] seed_value;
    logic        req;
    logic [31:0] rnd_out;
    logic        rnd_valid;

    int checks;
    int errors;
    bit done;
    string cur_tag;

    logic [31:0] m_state;
    logic        e1_v;
    logic [31:0] e1_d;
    logic        exp_valid;
    logic [31:0] exp_out;

    xs32_hash_rng i_xs32_hash_rng (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_value(seed_value),
        .req       (req),
        .rnd_out   (rnd_out),
        .rnd_valid (rnd_valid)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    function automatic logic [31:0] m_xs(input logic [31:0] v);
        logic [31:0] x;
        x = v;
        x = x ^ {x[18:0], 13'd0};
        x = x ^ {17'd0, x[31:17]};
        x = x ^ {x[26:0], 5'd0};
        return x;
    endfunction

    function automatic logic [31:0] m_hash(input logic [31:0] v);
        logic [31:0] t;
        t = v + {v[13:0], v[31:14]};
        t = t + ({t[24:0], t[31:25]} ^ {t[20:0], t[31:21]});
        return t;
    endfunction

    task automatic report_summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic check_outputs();
        checks++;
        if (rnd_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s valid: got %0b expected %0b", cur_tag, rnd_valid, exp_valid);
        end
        checks++;
        if (rnd_out !== exp_out) begin
            errors++;
            $display("FAIL %s word: got %08h expected %08h", cur_tag, rnd_out, exp_out);
        end
    endtask

    task automatic model_reset();
        m_state   = 32'd1;
        e1_v      = 1'b0;
        e1_d      = '0;
        exp_valid = 1'b0;
        exp_out   = '0;
    endtask

    // called at a falling edge: check, drive, advance model over the next rising edge
    task automatic step(input logic r, input logic l, input logic [31:0] sd);
        logic [31:0] ns;
        check_outputs();
        req        = r;
        seed_load  = l;
        seed_value = sd;
        exp_valid  = e1_v;
        if (e1_v) exp_out = e1_d;
        if (l) begin
            m_state = (sd == 32'd0) ? 32'd1 : sd;
            e1_v    = 1'b0;
        end else if (r) begin
            ns      = m_xs(m_state);
            e1_d    = m_hash(m_state) ^ ns;
            m_state = ns;
            e1_v    = 1'b1;
        end else begin
            e1_v = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        req       = 1'b1;
        seed_load = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        cur_tag = "R1 reset";
        check_outputs();
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report_summary();
    end

    initial begin
        checks     = 0;
        errors     = 0;
        done       = 1'b0;
        seed_value = '0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1: first words from the reset state
        cur_tag = "R1 first word";
        step(1'b1, 1'b0, 32'd0);
        step(1'b0, 1'b0, 32'd0);
        step(1'b0, 1'b0, 32'd0);

        // R6, R5: long back-to-back burst
        cur_tag = "R6 burst R5";
        for (int i = 0; i < 10500; i++) step(1'b1, 1'b0, 32'd0);

        // R9, R10: idle gaps between isolated requests
        cur_tag = "R10 idle R9";
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, 32'd0);
            repeat (i % 4) step(1'b0, 1'b0, 32'd0);
        end

        // R7: non-zero seed, then load together with a request
        cur_tag = "R7 seed";
        step(1'b0, 1'b1, 32'hDEADBEEF);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 32'd0);
        step(1'b1, 1'b1, 32'h00C0FFEE);
        step(1'b0, 1'b0, 32'd0);
        step(1'b0, 1'b0, 32'd0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 32'd0);

        // R8: zero seed
        cur_tag = "R8 zero seed";
        step(1'b1, 1'b1, 32'd0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'd0);

        // R1: reset in mid-run
        do_reset();
        cur_tag = "R1 after reset";
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'd0);

        // R2, R3, R4: random mix after a seed load
        cur_tag = "R2 R3 R4 random";
        step(1'b0, 1'b1, 32'h13579BDF);
        for (int i = 0; i < 12000; i++) begin
            logic r;
            logic l;
            logic [31:0] sd;
            r  = ($urandom % 4) != 0;
            l  = ($urandom % 500) == 0;
            sd = (($urandom % 3) == 0) ? 32'd0 : $urandom;
            step(r, l, sd);
        end
        step(1'b0, 1'b0, 32'd0);
        step(1'b0, 1'b0, 32'd0);
        check_outputs();
        report_summary();
    end
endmodule